// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives the word addresses and the data-valid timing for synchronous burst reads from a memory array. A host latches a start address together with a configuration word. The sequencer then holds a wait indication for a programmable number of clocks. After that it walks four word addresses that wrap inside the aligned four-word group holding the start address. Each address comes with a one-cycle data-valid strobe.

One configuration bit stretches every word to two clocks, for hosts that sample slowly. Some latency codes are only legal while that stretch is on. A latch that carries an illegal code is rejected and flagged. Another configuration bit selects asynchronous operation, where each latch produces exactly one random read with no wait and no burst. A latch that arrives while a burst is running abandons that burst and starts over from the new address.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, `wait_o`, `dvalid_o` and `cfg_err_o` are 0 and `word_addr_o` is 0.
- R2: In a burst, the four words have addresses whose bits above bit 1 equal those of the start address. Their two low bits are the start's two low bits plus 0, 1, 2 and 3, modulo 4. A start at word 7 therefore gives 7, 4, 5, 6.
- R3: The latency code L is held in cfg_i[13:11]. Call edge T the clock edge that samples `latch_i` high with an accepted synchronous configuration. The first `dvalid_o` pulse appears just after edge T+L.
- R4: `wait_o` is high from edge T up to edge T+L, falls at the edge where the first word becomes valid, and is never high together with `dvalid_o`.
- R5: With cfg_i[9]=0, `dvalid_o` is high for exactly four consecutive cycles (after edges T+L to T+L+3) and then low.
- R6: With cfg_i[9]=1, `dvalid_o` pulses after edges T+L, T+L+2, T+L+4 and T+L+6, and is low in between. `word_addr_o` holds each word's address for both cycles of that word.
- R7: With cfg_i[15]=1, a latch is rejected when its code is 0 or 7, or when its code is 5 or 6 while cfg_i[9]=0. A rejected latch sets `cfg_err_o` to 1 just after edge T and starts no burst: `wait_o` and `dvalid_o` stay 0.
- R8: With cfg_i[15]=0, a latch produces one `dvalid_o` pulse just after edge T with `word_addr_o` equal to the latched address. In this mode `wait_o` stays 0, the latency code is ignored and `cfg_err_o` is 0.
- R9: A latch that arrives during the wait or data phase of a burst abandons that burst. The new latch restarts the latency count and the address walk from the new start address.
- R10: `cfg_err_o` holds until the next latch and is cleared by any latch that is not rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_i | input | 1 | Address latch strobe, one cycle |
| addr_i | input | ADDR_W | Start word address, sampled with latch_i |
| cfg_i | input | CFG_W | Configuration word: bit 15 = synchronous mode, bits 13:11 = latency code, bit 9 = two-clock word hold |
| word_addr_o | output | ADDR_W | Array word address |
| dvalid_o | output | 1 | One pulse per delivered word |
| wait_o | output | 1 | Host wait indication during first-access latency |
| cfg_err_o | output | 1 | Last latch carried an illegal latency code |

## Verification
The bench sweeps all eight start offsets across two base groups, together with every legal latency and both hold settings. These sweeps catch a sequencer that carries into bit 2 instead of wrapping, which would step from word 7 to word 8. They also catch one that is off by one in the latency count, where wait falls a cycle early or late, and one that leaves out the gap cycles of hold mode. Latches with codes 5 and 6 and the hold bit clear must raise the error flag and stay silent; a design that accepted them would start a burst. Relatching in the middle of the wait phase and again in the middle of the data phase exposes a design that finishes the old burst or keeps the old counter value.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int LAT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } seq_state_t;

  // Latency codes 1..4 are always usable; 5 and 6 need the two-clock hold.
  function automatic logic lat_code_ok(input logic [LAT_W-1:0] code,
                                       input logic hold);
    if (code == '0 || code == '1) return 1'b0;
    if (code >= LAT_W'(5)) return hold;
    return 1'b1;
  endfunction

endpackage

// File: rtl/bas_lat_cnt.sv
module bas_lat_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (en_i && !zero_o)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bas_wrap_addr.sv
module bas_wrap_addr #(
  parameter int ADDR_W = 21,
  parameter int OFS_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [OFS_W-1:0] low;

  // Offset wraps inside the aligned group; the upper bits never change.
  assign low    = base_i[OFS_W-1:0] + idx_i;
  assign addr_o = {base_i[ADDR_W-1:OFS_W], low};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int OFS_W    = 2,
  parameter int CFG_W    = 16,
  parameter int MODE_BIT = 15,
  parameter int LAT_LSB  = 11,
  parameter int HOLD_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              dvalid_o,
  output logic              wait_o,
  output logic              cfg_err_o
);

  localparam logic [OFS_W-1:0] LAST_IDX = '1;

  logic [LAT_W-1:0] lat_code;
  logic             cfg_sync, cfg_hold, code_ok, accept;
  logic             cfg_unused;

  assign lat_code   = cfg_i[LAT_LSB +: LAT_W];
  assign cfg_sync   = cfg_i[MODE_BIT];
  assign cfg_hold   = cfg_i[HOLD_BIT];
  assign code_ok    = lat_code_ok(lat_code, cfg_hold);
  assign accept     = latch_i && cfg_sync && code_ok;
  assign cfg_unused = ^cfg_i;

  seq_state_t        state_q;
  logic [ADDR_W-1:0] base_q;
  logic              hold_q;
  logic              phase_q;
  logic [OFS_W-1:0]  word_q;

  logic              cnt_zero;
  logic [OFS_W-1:0]  next_idx;
  logic [ADDR_W-1:0] next_addr;

  bas_lat_cnt #(.CNT_W(LAT_W)) u_lat (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .load_val_i (lat_code - 1'b1),
    .en_i       (state_q == ST_WAIT),
    .zero_o     (cnt_zero)
  );

  assign next_idx = (state_q == ST_WAIT) ? '0 : word_q + 1'b1;

  bas_wrap_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_wrap (
    .base_i (base_q),
    .idx_i  (next_idx),
    .addr_o (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      hold_q      <= 1'b0;
      phase_q     <= 1'b0;
      word_q      <= '0;
      word_addr_o <= '0;
      dvalid_o    <= 1'b0;
      wait_o      <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else if (latch_i) begin
      // Any latch abandons whatever was in progress.
      phase_q <= 1'b0;
      word_q  <= '0;
      if (!cfg_sync) begin
        state_q     <= ST_IDLE;
        word_addr_o <= addr_i;
        dvalid_o    <= 1'b1;
        wait_o      <= 1'b0;
        cfg_err_o   <= 1'b0;
      end else if (!code_ok) begin
        state_q   <= ST_IDLE;
        dvalid_o  <= 1'b0;
        wait_o    <= 1'b0;
        cfg_err_o <= 1'b1;
      end else begin
        state_q     <= ST_WAIT;
        base_q      <= addr_i;
        hold_q      <= cfg_hold;
        word_addr_o <= addr_i;
        dvalid_o    <= 1'b0;
        wait_o      <= 1'b1;
        cfg_err_o   <= 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (cnt_zero) begin
            state_q     <= ST_DATA;
            wait_o      <= 1'b0;
            dvalid_o    <= 1'b1;
            word_addr_o <= next_addr;
            word_q      <= '0;
            phase_q     <= 1'b0;
          end
        end
        ST_DATA: begin
          if (hold_q && !phase_q) begin
            phase_q  <= 1'b1;
            dvalid_o <= 1'b0;
          end else if (word_q == LAST_IDX) begin
            state_q  <= ST_IDLE;
            dvalid_o <= 1'b0;
          end else begin
            word_q      <= next_idx;
            phase_q     <= 1'b0;
            dvalid_o    <= 1'b1;
            word_addr_o <= next_addr;
          end
        end
        default: dvalid_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 21,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_i,
  input logic              cfg_sync,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic              dvalid_o,
  input logic              wait_o,
  input logic              cfg_err_o
);

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(wait_o && dvalid_o));

  assert_wait_until_data_R4: assert property (@(posedge clk) disable iff (rst)
    (wait_o && !latch_i) |=> (wait_o || dvalid_o));

  assert_async_single_R8: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !cfg_sync) |=>
      (dvalid_o && !wait_o && !cfg_err_o && word_addr_o == $past(addr_i)));

  assert_wrap_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dvalid_o && !latch_i) |=>
      (!dvalid_o ||
       (word_addr_o[ADDR_W-1:OFS_W] == $past(word_addr_o[ADDR_W-1:OFS_W]) &&
        word_addr_o[OFS_W-1:0] == $past(word_addr_o[OFS_W-1:0]) + 1'b1)));

  assert_accept_or_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (latch_i && cfg_sync) |=> (wait_o != cfg_err_o));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (!wait_o && !dvalid_o));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_err_o && !latch_i) |=> cfg_err_o);

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_bas_checker (
  .clk         (clk),
  .rst         (rst),
  .latch_i     (latch_i),
  .cfg_sync    (cfg_i[MODE_BIT]),
  .addr_i      (addr_i),
  .word_addr_o (word_addr_o),
  .dvalid_o    (dvalid_o),
  .wait_o      (wait_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          latch_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   cfg_i = '0;
  logic [AW-1:0] word_addr_o;
  logic          dvalid_o, wait_o, cfg_err_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst(rst), .latch_i(latch_i), .addr_i(addr_i), .cfg_i(cfg_i),
    .word_addr_o(word_addr_o), .dvalid_o(dvalid_o), .wait_o(wait_o),
    .cfg_err_o(cfg_err_o)
  );

  function automatic logic [15:0] mkcfg(input bit sync, input int lat, input bit hold);
    logic [15:0] c;
    c = '0;
    c[15]    = sync;
    c[13:11] = 3'(lat);
    c[9]     = hold;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the sampling edge.
  task automatic do_latch(input logic [AW-1:0] a, input logic [15:0] c);
    addr_i  = a;
    cfg_i   = c;
    latch_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    latch_i = 1'b0;
  endtask

  task automatic observe(input logic [AW-1:0] st, input int lat, input bit hold, input int n);
    for (int k = 0; k < n; k++) begin
      int            rel;
      int            step;
      bit            in_data;
      bit            exp_dv;
      bit            exp_wt;
      logic [AW-1:0] exp_a;
      string         dreq;
      rel     = k - lat;
      step    = hold ? 2 : 1;
      in_data = (rel >= 0) && (rel < 4 * step);
      exp_dv  = in_data && (rel % step == 0);
      exp_wt  = (k < lat);
      exp_a   = {st[AW-1:2], 2'(int'(st[1:0]) + (in_data ? rel / step : 0))};
      dreq    = (k == lat) ? "R3" : (hold ? "R6" : "R5");
      check(wait_o == exp_wt, "R4", "wait", wait_o, exp_wt);
      check(dvalid_o == exp_dv, dreq, "dvalid", dvalid_o, exp_dv);
      if (in_data) check(word_addr_o == exp_a, hold ? "R2/R6" : "R2", "addr", word_addr_o, exp_a);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] bases [2];
    bases[0] = 21'h000000;
    bases[1] = 21'h1FFFF8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(wait_o == 1'b0, "R1", "wait", wait_o, 0);
    check(dvalid_o == 1'b0, "R1", "dvalid", dvalid_o, 0);
    check(cfg_err_o == 1'b0, "R1", "err", cfg_err_o, 0);
    check(word_addr_o == '0, "R1", "addr", word_addr_o, 0);

    // R2, R3, R4, R5, R6: sweep offsets, latencies and hold
    for (int h = 0; h < 2; h++) begin
      for (int lat = 1; lat <= 6; lat++) begin
        if (h == 0 && lat >= 5) continue;
        for (int b = 0; b < 2; b++) begin
          for (int s = 0; s < 8; s++) begin
            logic [AW-1:0] st;
            st = bases[b] + AW'(s);
            do_latch(st, mkcfg(1'b1, lat, h[0]));
            observe(st, lat, h[0], lat + 10);
          end
        end
      end
    end

    // R7: rejected codes; R10: error cleared by the next accepted latch
    for (int c = 0; c < 8; c++) begin
      for (int h = 0; h < 2; h++) begin
        bit bad;
        bad = (c == 0) || (c == 7) || ((c == 5 || c == 6) && h == 0);
        if (!bad) continue;
        do_latch(21'h000123, mkcfg(1'b1, c, h[0]));
        for (int k = 0; k < 10; k++) begin
          check(cfg_err_o == 1'b1, "R7", "err", cfg_err_o, 1);
          check(wait_o == 1'b0, "R7", "wait", wait_o, 0);
          check(dvalid_o == 1'b0, "R7", "dvalid", dvalid_o, 0);
          @(negedge clk);
        end
        do_latch(21'h000042, mkcfg(1'b1, 2, 1'b0));
        check(cfg_err_o == 1'b0, "R10", "err clear", cfg_err_o, 0);
        observe(21'h000042, 2, 1'b0, 8);
      end
    end

    // R8: asynchronous single reads, latency field ignored, error cleared
    do_latch(21'h000000, mkcfg(1'b1, 6, 1'b0));
    check(cfg_err_o == 1'b1, "R7", "err set", cfg_err_o, 1);
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a;
      a = 21'h0ABCD0 + AW'(i * 5);
      do_latch(a, mkcfg(1'b0, 7 - i, i[0]));
      check(dvalid_o == 1'b1, "R8", "dvalid", dvalid_o, 1);
      check(word_addr_o == a, "R8", "addr", word_addr_o, a);
      check(wait_o == 1'b0, "R8", "wait", wait_o, 0);
      check(cfg_err_o == 1'b0, "R8", "err", cfg_err_o, 0);
      @(negedge clk);
      check(dvalid_o == 1'b0, "R8", "single pulse", dvalid_o, 0);
      check(wait_o == 1'b0, "R8", "no wait", wait_o, 0);
      @(negedge clk);
    end

    // R9: abort during wait phase
    do_latch(21'h000011, mkcfg(1'b1, 4, 1'b0));
    observe(21'h000011, 4, 1'b0, 3);
    do_latch(21'h00002E, mkcfg(1'b1, 3, 1'b1));
    check(wait_o == 1'b1, "R9", "restart wait", wait_o, 1);
    observe(21'h00002E, 3, 1'b1, 14);
    // R9: abort during data phase
    do_latch(21'h000035, mkcfg(1'b1, 1, 1'b0));
    observe(21'h000035, 1, 1'b0, 3);
    do_latch(21'h00007B, mkcfg(1'b1, 2, 1'b0));
    check(dvalid_o == 1'b0, "R9", "abort data", dvalid_o, 0);
    observe(21'h00007B, 2, 1'b0, 9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule